// File: doc/BRIEF.md
# Windowed Watchdog with Configuration Lock

The block is a watchdog counter clocked by its own slow clock. Software picks a time-out period and, optionally, a window length. With the window length at zero the watchdog runs in normal mode: a restart must arrive before the period expires. With a non-zero window length, every period starts with a closed window of that length, in which a restart counts as a fault. The open window that follows has the period length, and a restart must arrive within it. A missed restart or an early restart raises a one-cycle reset request.

A sticky lock bit freezes the configuration, so that software can neither change nor switch off a running watchdog. Software can only set the lock. It can be cleared only while the debug-mode input is high. A fuse-load strobe loads both selections from an external fuse source and forces the lock on. A debug-halt input holds the counter at zero. When the halt ends, the first interval is a plain normal-mode period with no closed window, even when window mode is selected.

All inputs are taken in the watchdog clock domain. The counter runs on every edge of that clock. It therefore keeps running through any low-power state in which the clock stays active.

Top module: `winWatchdog`

## Requirements
- R1: A period selection of 0 disables the watchdog, and rstReq stays low. A non-zero selection s gives an interval of 4 * 2^(s-1) watchdog cycles (s=1 gives 4, s=2 gives 8, s=3 gives 16). The window selection uses the same encoding. After reset both selections are 0 and the lock is clear.
- R2: In normal mode (window selection 0), rstReq rises exactly P cycles after the configuring edge or the last restart edge, where P is the period length.
- R3: A restart in normal mode, or in the open window, restarts the interval and raises no reset request. A restart on the very edge where the open window would expire also counts as valid.
- R4: In window mode, each interval is a closed window of W cycles followed by an open window of P cycles. A missing restart raises rstReq W+P cycles after the interval start, and inClosed is high during the closed window.
- R5: A restart taken on any of the W edges of the closed window, including its last edge, raises rstReq in the following cycle and starts a new interval.
- R6: Writing 1 to the lock sets it. Writing 0 while dbgMode is low leaves it set.
- R7: Writing 0 to the lock while dbgMode is high clears it.
- R8: While the lock is set, configuration writes are ignored. This includes an attempt to write period 0, so the watchdog still expires.
- R9: A fuseLoad strobe loads the period and window selections from the fuse inputs, even while locked, sets the lock, and starts a new interval.
- R10: While dbgHalt is high, the counter is held at zero and rstReq stays low for any length of halt.
- R11: When the halt ends in window mode, the first interval has no closed window. A restart right after resume is valid, and without a restart rstReq rises P cycles after the last halted edge.
- R12: rstReq is a single-cycle pulse unless a restart lands in a fresh closed window on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgPeriodIn | input | SEL_W | Period selection to write |
| cfgWindowIn | input | SEL_W | Window selection to write |
| lockWrEn | input | 1 | Lock bit write strobe |
| lockWrData | input | 1 | Value written to the lock bit |
| fuseLoad | input | 1 | Load configuration from fuses and force lock |
| fusePeriod | input | SEL_W | Period selection from fuses |
| fuseWindow | input | SEL_W | Window selection from fuses |
| dbgMode | input | 1 | Debug mode active, permits clearing the lock |
| dbgHalt | input | 1 | CPU halted by debugger |
| restart | input | 1 | Watchdog restart request |
| rstReq | output | 1 | Reset request pulse |
| locked | output | 1 | Lock bit state |
| cfgPeriod | output | SEL_W | Active period selection |
| cfgWindow | output | SEL_W | Active window selection |
| inClosed | output | 1 | Closed window in progress |

## Verification
Two pairs of functions can fall on the same edge. The first pair is a restart and the expiry of a window. A restart on the last closed-window edge must still count as a fault, while a restart on the last open-window edge must count as a valid service. The random loop draws the restart edge across the whole closed-plus-open span, and the directed cases place it on both boundaries. Each outcome is judged against the bench's own interval arithmetic. The second pair is resume from halt and a restart. Both are driven into the same edge, and the bench expects no reset request because the closed window is skipped.

// File: rtl/wdogPkg.sv
package wdogPkg;

  // Command strobes from control to counter datapath
  typedef struct packed {
    logic clr;     // force counter to zero
    logic inc;     // advance counter by one
    logic useWin;  // compare against closed-window length
  } cntCmd_t;

  // Interval length in watchdog cycles for a selection code
  function automatic int unsigned selToCycles(input int unsigned sel,
                                              input int unsigned baseCyc);
    if (sel == 0) return baseCyc;
    return baseCyc << (sel - 1);
  endfunction

endpackage

// File: rtl/wdCounter.sv
module wdCounter
  import wdogPkg::*;
#(
  parameter int unsigned SEL_W    = 4,
  parameter int unsigned CNT_W    = 20,
  parameter int unsigned BASE_CYC = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntCmd_t          cmd,
  input  logic [SEL_W-1:0] periodSel,
  input  logic [SEL_W-1:0] windowSel,
  output logic             cntHit
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;
  logic [SEL_W-1:0] selNow;

  assign selNow = cmd.useWin ? windowSel : periodSel;
  assign limit  = CNT_W'(selToCycles(int'(selNow), BASE_CYC));
  assign cntHit = (cnt == limit - CNT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (cmd.clr) begin
      cnt <= '0;
    end else if (cmd.inc) begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    cnt < limit) else $error("counter beyond interval"); // R2

endmodule

// File: rtl/wdControl.sv
module wdControl
  import wdogPkg::*;
#(
  parameter int unsigned SEL_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [SEL_W-1:0] cfgPeriodIn,
  input  logic [SEL_W-1:0] cfgWindowIn,
  input  logic             lockWrEn,
  input  logic             lockWrData,
  input  logic             fuseLoad,
  input  logic [SEL_W-1:0] fusePeriod,
  input  logic [SEL_W-1:0] fuseWindow,
  input  logic             dbgMode,
  input  logic             dbgHalt,
  input  logic             restart,
  input  logic             cntHit,
  output cntCmd_t          cmd,
  output logic             rstReq,
  output logic             locked,
  output logic [SEL_W-1:0] periodSel,
  output logic [SEL_W-1:0] windowSel,
  output logic             inClosed
);

  logic             lockBit;
  logic             closedPh;
  logic             closedNext;
  logic             errNow;
  logic             cfgTake;
  logic             loadNow;
  logic             enabled;
  logic             winMode;
  logic [SEL_W-1:0] nextWindow;

  assign cfgTake    = cfgWrEn && !lockBit;
  assign loadNow    = fuseLoad || cfgTake;
  assign nextWindow = fuseLoad ? fuseWindow : cfgWindowIn;
  assign enabled    = (periodSel != '0);
  assign winMode    = (windowSel != '0);

  // Configuration and lock registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      periodSel <= '0;
      windowSel <= '0;
      lockBit   <= 1'b0;
    end else if (fuseLoad) begin
      periodSel <= fusePeriod;
      windowSel <= fuseWindow;
      lockBit   <= 1'b1;
    end else begin
      if (cfgTake) begin
        periodSel <= cfgPeriodIn;
        windowSel <= cfgWindowIn;
      end
      if (lockWrEn) begin
        if (lockWrData)   lockBit <= 1'b1;
        else if (dbgMode) lockBit <= 1'b0;
      end
    end
  end

  // Interval sequencing
  always_comb begin
    cmd        = '0;
    errNow     = 1'b0;
    closedNext = closedPh;
    if (dbgHalt) begin
      cmd.clr    = 1'b1;
      closedNext = 1'b0;
    end else if (loadNow) begin
      cmd.clr    = 1'b1;
      closedNext = (nextWindow != '0);
    end else if (!enabled) begin
      cmd.clr    = 1'b1;
      closedNext = winMode;
    end else if (restart) begin
      cmd.clr    = 1'b1;
      errNow     = closedPh;
      closedNext = winMode;
    end else if (cntHit) begin
      cmd.clr    = 1'b1;
      errNow     = !closedPh;
      closedNext = closedPh ? 1'b0 : winMode;
    end else begin
      cmd.inc = 1'b1;
    end
    cmd.useWin = closedPh;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      closedPh <= 1'b0;
      rstReq   <= 1'b0;
    end else begin
      closedPh <= closedNext;
      rstReq   <= errNow;
    end
  end

  assign locked   = lockBit;
  assign inClosed = closedPh;

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (periodSel == '0) |=> !rstReq) else $error("request while disabled"); // R1
  AST_EARLY_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (restart && inClosed && enabled && !dbgHalt && !fuseLoad && !(cfgWrEn && !locked))
      |=> rstReq) else $error("closed-window restart missed"); // R5
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (locked && !dbgMode) |=> locked) else $error("lock dropped"); // R6
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (locked && !fuseLoad) |=> ($stable(periodSel) && $stable(windowSel)))
    else $error("locked config changed"); // R8
  AST_FUSE_LOCKS: assert property (@(posedge clk) disable iff (!rstN)
    fuseLoad |=> locked) else $error("fuse load left unlocked"); // R9
  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    dbgHalt |=> !rstReq) else $error("request during halt"); // R10
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (rstReq && !restart) |=> !rstReq) else $error("request stretched"); // R12

endmodule

// File: rtl/winWatchdog.sv
module winWatchdog
  import wdogPkg::*;
#(
  parameter int unsigned SEL_W    = 4,
  parameter int unsigned CNT_W    = 20,
  parameter int unsigned BASE_CYC = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [SEL_W-1:0] cfgPeriodIn,
  input  logic [SEL_W-1:0] cfgWindowIn,
  input  logic             lockWrEn,
  input  logic             lockWrData,
  input  logic             fuseLoad,
  input  logic [SEL_W-1:0] fusePeriod,
  input  logic [SEL_W-1:0] fuseWindow,
  input  logic             dbgMode,
  input  logic             dbgHalt,
  input  logic             restart,
  output logic             rstReq,
  output logic             locked,
  output logic [SEL_W-1:0] cfgPeriod,
  output logic [SEL_W-1:0] cfgWindow,
  output logic             inClosed
);

  cntCmd_t cmd;
  logic    cntHit;

  wdControl #(.SEL_W(SEL_W)) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cfgWrEn    (cfgWrEn),
    .cfgPeriodIn(cfgPeriodIn),
    .cfgWindowIn(cfgWindowIn),
    .lockWrEn   (lockWrEn),
    .lockWrData (lockWrData),
    .fuseLoad   (fuseLoad),
    .fusePeriod (fusePeriod),
    .fuseWindow (fuseWindow),
    .dbgMode    (dbgMode),
    .dbgHalt    (dbgHalt),
    .restart    (restart),
    .cntHit     (cntHit),
    .cmd        (cmd),
    .rstReq     (rstReq),
    .locked     (locked),
    .periodSel  (cfgPeriod),
    .windowSel  (cfgWindow),
    .inClosed   (inClosed)
  );

  wdCounter #(.SEL_W(SEL_W), .CNT_W(CNT_W), .BASE_CYC(BASE_CYC)) i_cnt (
    .clk      (clk),
    .rstN     (rstN),
    .cmd      (cmd),
    .periodSel(cfgPeriod),
    .windowSel(cfgWindow),
    .cntHit   (cntHit)
  );

endmodule

// File: tb/test_winWatchdog.sv
module test_winWatchdog;

  localparam int SEL_W = 4;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             cfgWrEn = 1'b0;
  logic [SEL_W-1:0] cfgPeriodIn = '0;
  logic [SEL_W-1:0] cfgWindowIn = '0;
  logic             lockWrEn = 1'b0;
  logic             lockWrData = 1'b0;
  logic             fuseLoad = 1'b0;
  logic [SEL_W-1:0] fusePeriod = '0;
  logic [SEL_W-1:0] fuseWindow = '0;
  logic             dbgMode = 1'b0;
  logic             dbgHalt = 1'b0;
  logic             restart = 1'b0;
  logic             rstReq;
  logic             locked;
  logic [SEL_W-1:0] cfgPeriod;
  logic [SEL_W-1:0] cfgWindow;
  logic             inClosed;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  winWatchdog i_winWatchdog (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgPeriodIn(cfgPeriodIn),
    .cfgWindowIn(cfgWindowIn), .lockWrEn(lockWrEn), .lockWrData(lockWrData),
    .fuseLoad(fuseLoad), .fusePeriod(fusePeriod), .fuseWindow(fuseWindow),
    .dbgMode(dbgMode), .dbgHalt(dbgHalt), .restart(restart), .rstReq(rstReq),
    .locked(locked), .cfgPeriod(cfgPeriod), .cfgWindow(cfgWindow),
    .inClosed(inClosed)
  );

  function automatic int cyc(input int sel);
    return 4 << (sel - 1);
  endfunction

  function automatic int spanOf(input int p, input int w);
    return (w != 0 ? cyc(w) : 0) + cyc(p);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic writeCfg(input int p, input int w);
    cfgPeriodIn = SEL_W'(p);
    cfgWindowIn = SEL_W'(w);
    cfgWrEn = 1'b1;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic writeLock(input logic d);
    lockWrData = d;
    lockWrEn = 1'b1;
    @(negedge clk);
    lockWrEn = 1'b0;
  endtask

  // Cycles until rstReq is seen (0 if never within maxN); also checks width
  task automatic waitRst(input int maxN, output int seen);
    seen = 0;
    for (int j = 1; j <= maxN; j++) begin
      @(negedge clk);
      if (rstReq) begin
        seen = j;
        break;
      end
    end
    if (seen != 0) begin
      @(negedge clk);
      chk("R12 pulse width", int'(rstReq), 0);
    end
  endtask

  // Pulse restart so it is taken on edge k after the interval start
  task automatic restartAt(input int k);
    tick(k - 1);
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
  endtask

  initial begin
    int seen;
    int p, w, k, span;
    bit early;
    void'($urandom(32'd2024));

    tick(2);
    rstN = 1'b1;
    tick(1);
    chk("R1 reset rstReq", int'(rstReq), 0);
    chk("R1 reset locked", int'(locked), 0);
    chk("R1 reset period", int'(cfgPeriod), 0);

    // R1: disabled watchdog stays quiet
    waitRst(80, seen);
    chk("R1 disabled no request", seen, 0);

    // R2: normal mode time-out
    writeCfg(2, 0);
    waitRst(100, seen);
    chk("R2 normal timeout", seen, cyc(2));

    // R3: restart on the expiry edge of the open period is valid
    writeCfg(1, 0);
    restartAt(cyc(1));
    chk("R3 restart at boundary", int'(rstReq), 0);
    waitRst(100, seen);
    chk("R3 interval restarted", seen, cyc(1));

    // R4: window mode time-out and closed status
    writeCfg(1, 2);
    chk("R4 inClosed at start", int'(inClosed), 1);
    waitRst(100, seen);
    chk("R4 window timeout", seen, spanOf(1, 2));

    // R5: restart on last closed edge is a fault
    writeCfg(1, 1);
    restartAt(cyc(1));
    chk("R5 restart last closed edge", int'(rstReq), 1);

    // Random restarts across closed and open windows (R3, R4, R5)
    for (int it = 0; it < 24; it++) begin
      p = 1 + int'($urandom_range(2));
      w = int'($urandom_range(3));
      span = spanOf(p, w);
      k = 1 + int'($urandom_range(span - 1));
      early = (w != 0) && (k <= cyc(w));
      writeCfg(p, w);
      restartAt(k);
      chk(early ? "R5 random early restart" : "R3 random valid restart",
          int'(rstReq), early ? 1 : 0);
      waitRst(200, seen);
      chk("R4 random next interval", seen, span);
    end

    // R6: lock set, write 0 without debug ignored
    writeCfg(1, 0);
    writeLock(1'b1);
    chk("R6 lock set", int'(locked), 1);
    writeLock(1'b0);
    chk("R6 lock sticky", int'(locked), 1);

    // R8: config writes ignored while locked, cannot disable
    writeCfg(0, 0);
    chk("R8 period kept", int'(cfgPeriod), 1);
    waitRst(100, seen);
    chk("R8 still expires", seen == 0 ? 0 : 1, 1);

    // R7: debug mode clears lock
    dbgMode = 1'b1;
    writeLock(1'b0);
    dbgMode = 1'b0;
    chk("R7 lock cleared", int'(locked), 0);
    writeCfg(3, 0);
    chk("R7 write accepted", int'(cfgPeriod), 3);

    // R9: fuse load overrides and locks
    writeLock(1'b1);
    fusePeriod = SEL_W'(2);
    fuseWindow = SEL_W'(1);
    fuseLoad = 1'b1;
    @(negedge clk);
    fuseLoad = 1'b0;
    chk("R9 fuse period", int'(cfgPeriod), 2);
    chk("R9 fuse window", int'(cfgWindow), 1);
    chk("R9 fuse lock", int'(locked), 1);
    waitRst(100, seen);
    chk("R9 fuse interval", seen, spanOf(2, 1));

    // Unlock and configure window mode for halt tests
    dbgMode = 1'b1;
    writeLock(1'b0);
    dbgMode = 1'b0;
    writeCfg(1, 2);

    // R10: halt holds counter, no request
    tick(3);
    dbgHalt = 1'b1;
    waitRst(60, seen);
    chk("R10 halt quiet", seen, 0);
    // R11: resume with restart on the first edge is valid
    dbgHalt = 1'b0;
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
    chk("R11 restart on resume", int'(rstReq), 0);
    waitRst(100, seen);
    chk("R11 window after resume restart", seen, spanOf(1, 2));

    // R11: resume without restart runs a normal period
    dbgHalt = 1'b1;
    tick(10);
    dbgHalt = 1'b0;
    chk("R11 no closed after resume", int'(inClosed), 0);
    waitRst(100, seen);
    chk("R11 normal period after resume", seen, cyc(1));

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog timeout actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule